// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block converts single-register requests from a controller into byte commands for an I2C master. The master is assumed to handle bit timing, START/STOP generation and acknowledge sampling. Three operations are supported: write one register, read one register, and poll one register until chosen bits reach a chosen state. Every transfer addresses a fixed 7-bit slave.

A register read is built from two bus transactions. The first writes the register pointer and closes with STOP. The second is an independent one-byte read. A repeated START is never used. The block remembers whether the last bus transaction was a read. If it was, the block waits out a guard interval before it opens any transaction that begins with a write. A read that fails, or that returns all-ones, is tried again up to a fixed number of attempts, except on the FIFO register. A poll repeats whole reads with a fixed pause between them until the masks match or the accumulated pause reaches the requested limit. All delays are counted in clock cycles, derived from the clock frequency parameter by a single down-counter.

Top module: `i2c_reg_seq`

## Requirements
- R1: A write request (reqOp=1) issues three byte commands to the master. The first carries START and the byte {SLAVE_ADDR, 0}, with SLAVE_ADDR defaulting to 0x20. The second carries the register address. The third carries the data byte and STOP. The addressed register then holds the data.
- R2: A read request (reqOp=0, or the unused code 3) issues two transactions. The first is START, {SLAVE_ADDR,0}, then the register address with STOP. The second is START, {SLAVE_ADDR,1}, then one read byte with STOP. No START is issued while a transaction is still open. rspData returns the byte that was read.
- R3: If the last bus transaction was a read, the block waits at least GUARD_US microseconds before it starts a transaction that begins with a write. A write that follows a write starts without that delay.
- R4: If an attempt returns 0xFF, or fails, it is repeated until RETRIES attempts (default 3) have been made in total. The first attempt that returns a value other than 0xFF ends the read.
- R5: A read of the FIFO register (FIFO_REG, default 0x05) makes exactly one attempt, even when it returns 0xFF.
- R6: A read that was NACKed in its last attempt returns 0xFF. It sets rspErr, unless the register is the access register (ACCESS_REG, default 0x00), in which case rspErr stays 0.
- R7: A NACK on any byte of a write request aborts that write. The register is left unchanged and rspErr is set.
- R8: A poll request (reqOp=2) completes without timeout once the value read satisfies (value & reqSetMask) == reqSetMask and (value & reqClrMask) == 0. rspData returns that value.
- R9: Between poll reads the block waits STEP_US microseconds (default 30) and adds STEP_US to an elapsed total. The poll ends with rspTimeout=1 once the total is at least reqTimeoutUs. A limit of L therefore gives ceil(L/STEP_US) reads, and a limit of 0 gives no bus activity at all.
- R10: reqReady is high only while the block is idle. rspValid is a single-cycle pulse.
- R11: After reset, reqReady=1, cmdValid=0, rspValid=0, and no guard delay is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted when reqValid is high |
| reqOp | input | 2 | 0 read, 1 write, 2 poll, 3 read |
| reqReg | input | 8 | Register address |
| reqData | input | 8 | Write data |
| reqSetMask | input | 8 | Poll: bits that must be one |
| reqClrMask | input | 8 | Poll: bits that must be zero |
| reqTimeoutUs | input | TMO_W | Poll limit in microseconds |
| rspValid | output | 1 | Response pulse |
| rspData | output | 8 | Last value read |
| rspErr | output | 1 | Failed write or failed read of a non-access register |
| rspTimeout | output | 1 | Poll limit reached |
| cmdValid | output | 1 | Byte command held until mstDone |
| cmdStart | output | 1 | Issue START before this byte |
| cmdStop | output | 1 | Issue STOP after this byte |
| cmdRead | output | 1 | 1 read a byte, 0 write cmdByte |
| cmdByte | output | 8 | Byte to write |
| mstDone | input | 1 | Byte command complete, one-cycle pulse |
| mstNack | input | 1 | With mstDone: byte NACKed, master has closed the bus |
| mstRdByte | input | 8 | With mstDone: byte read |

## Verification
The retry decision and the poll-match decision are both made from the same value read. A read of 0xFF under a set mask that 0xFF satisfies would pass the match test, but the retry rule must take priority. To provoke this, the bench makes the slave answer 0xFF once on the polled register and then answer a matching value. It then checks that two reads were made, that the returned data is the later value, and that no timeout was reported. The bench also checks guard gaps and bus framing on every transaction, as it sweeps register addresses, poll limits and NACK placements.

// File: rtl/i2c_reg_seq_pkg.sv
package i2c_reg_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_RSVD  = 2'd3
  } seqOp_t;

  typedef enum logic [1:0] {
    BSEL_SLA_W,
    BSEL_SLA_R,
    BSEL_REG,
    BSEL_DATA
  } byteSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     loadReq;
    logic     loadGuard;
    logic     loadStep;
    logic     captureOk;
    logic     captureFail;
    logic     incAttempt;
    logic     clrAttempt;
    logic     addElapsed;
    logic     setPrevRead;
    logic     clrPrevRead;
    logic     setErr;
    logic     setTimeout;
    byteSel_t byteSel;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic   timerZero;
    logic   prevRead;
    logic   retryOk;
    logic   isAccess;
    logic   lastFail;
    logic   matchOk;
    logic   pollExpired;
    seqOp_t op;
  } seqStatus_t;

endpackage

// File: rtl/i2c_reg_seq_dp.sv
module i2c_reg_seq_dp
  import i2c_reg_seq_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h20,
  parameter int         GUARD_CYC  = 12500,
  parameter int         STEP_CYC   = 1500,
  parameter int         STEP_US    = 30,
  parameter int         RETRIES    = 3,
  parameter logic [7:0] FIFO_REG   = 8'h05,
  parameter logic [7:0] ACCESS_REG = 8'h00,
  parameter int         TMO_W      = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  output seqStatus_t       sts,
  input  logic [1:0]       reqOp,
  input  logic [7:0]       reqReg,
  input  logic [7:0]       reqData,
  input  logic [7:0]       reqSetMask,
  input  logic [7:0]       reqClrMask,
  input  logic [TMO_W-1:0] reqTimeoutUs,
  input  logic [7:0]       mstRdByte,
  output logic [7:0]       rspData,
  output logic             rspErr,
  output logic             rspTimeout,
  output logic [7:0]       cmdByte
);

  localparam int TMR_MAX = (GUARD_CYC > STEP_CYC) ? GUARD_CYC : STEP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int ATT_W   = $clog2(RETRIES + 1);
  localparam int ELA_W   = TMO_W + 1;

  seqOp_t           opQ;
  logic [7:0]       regQ, dataQ, setQ, clrQ, rdQ;
  logic [TMO_W-1:0] tmoQ;
  logic [ELA_W-1:0] elapsedQ;
  logic [TMR_W-1:0] tmrQ;
  logic [ATT_W-1:0] attQ;
  logic             prevReadQ, lastFailQ, errQ, toQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_READ; regQ <= '0; dataQ <= '0; setQ <= '0; clrQ <= '0;
      tmoQ <= '0; rdQ <= 8'hFF; elapsedQ <= '0; tmrQ <= '0; attQ <= '0;
      prevReadQ <= 1'b0; lastFailQ <= 1'b0; errQ <= 1'b0; toQ <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        opQ <= seqOp_t'(reqOp); regQ <= reqReg; dataQ <= reqData;
        setQ <= reqSetMask; clrQ <= reqClrMask; tmoQ <= reqTimeoutUs;
        elapsedQ <= '0; errQ <= 1'b0; toQ <= 1'b0;
      end else if (stb.addElapsed) begin
        elapsedQ <= elapsedQ + ELA_W'(STEP_US);
      end

      if (stb.loadGuard)      tmrQ <= TMR_W'(GUARD_CYC);
      else if (stb.loadStep)  tmrQ <= TMR_W'(STEP_CYC);
      else if (tmrQ != '0)    tmrQ <= tmrQ - 1'b1;

      if (stb.loadReq || stb.clrAttempt) attQ <= '0;
      else if (stb.incAttempt)           attQ <= attQ + 1'b1;

      if (stb.setPrevRead)      prevReadQ <= 1'b1;
      else if (stb.clrPrevRead) prevReadQ <= 1'b0;

      if (stb.captureOk) begin
        rdQ <= mstRdByte; lastFailQ <= 1'b0;
      end else if (stb.captureFail) begin
        rdQ <= 8'hFF; lastFailQ <= 1'b1;
      end

      if (stb.setErr)     errQ <= 1'b1;
      if (stb.setTimeout) toQ  <= 1'b1;
    end
  end

  always_comb begin
    sts.timerZero   = (tmrQ == '0);
    sts.prevRead    = prevReadQ;
    sts.retryOk     = (rdQ == 8'hFF) && (regQ != FIFO_REG) &&
                      ((int'(attQ) + 1) < RETRIES);
    sts.isAccess    = (regQ == ACCESS_REG);
    sts.lastFail    = lastFailQ;
    sts.matchOk     = ((rdQ & setQ) == setQ) && ((rdQ & clrQ) == 8'h00);
    sts.pollExpired = (elapsedQ >= {1'b0, tmoQ});
    sts.op          = opQ;
  end

  always_comb begin
    case (stb.byteSel)
      BSEL_SLA_W: cmdByte = {SLAVE_ADDR, 1'b0};
      BSEL_SLA_R: cmdByte = {SLAVE_ADDR, 1'b1};
      BSEL_REG:   cmdByte = regQ;
      default:    cmdByte = dataQ;
    endcase
  end

  assign rspData    = rdQ;
  assign rspErr     = errQ;
  assign rspTimeout = toQ;

endmodule

// File: rtl/i2c_reg_seq_ctrl.sv
module i2c_reg_seq_ctrl
  import i2c_reg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  seqStatus_t sts,
  output seqStrobe_t stb,
  output logic       cmdValid,
  output logic       cmdStart,
  output logic       cmdStop,
  output logic       cmdRead,
  input  logic       mstDone,
  input  logic       mstNack
);

  typedef enum logic [3:0] {
    S_IDLE, S_BEGIN, S_GUARD, S_WSLA, S_WREG, S_WDAT,
    S_RSLA, S_RBYTE, S_EVAL, S_CHECK, S_STEP, S_RESP
  } seqState_t;

  seqState_t state, nextState;
  logic isWrite;

  assign isWrite = (sts.op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb = '0;
    stb.byteSel = BSEL_SLA_W;
    nextState = state;
    cmdValid = 1'b0; cmdStart = 1'b0; cmdStop = 1'b0; cmdRead = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1; nextState = S_BEGIN;
      end
      S_BEGIN: begin
        if (sts.op == OP_POLL && sts.pollExpired) begin
          stb.setTimeout = 1'b1; nextState = S_RESP;
        end else if (sts.prevRead) begin
          stb.loadGuard = 1'b1; nextState = S_GUARD;
        end else nextState = S_WSLA;
      end
      S_GUARD: if (sts.timerZero) nextState = S_WSLA;
      S_WSLA, S_WREG: begin
        cmdValid = 1'b1;
        cmdStart = (state == S_WSLA);
        cmdStop  = (state == S_WREG) && !isWrite;
        stb.byteSel = (state == S_WSLA) ? BSEL_SLA_W : BSEL_REG;
        if (mstDone) begin
          if (mstNack) begin
            if (isWrite) begin
              stb.clrPrevRead = 1'b1; stb.setErr = 1'b1; nextState = S_RESP;
            end else begin
              stb.captureFail = 1'b1; nextState = S_EVAL;
            end
          end else if (state == S_WSLA) nextState = S_WREG;
          else nextState = isWrite ? S_WDAT : S_RSLA;
        end
      end
      S_WDAT: begin
        cmdValid = 1'b1; cmdStop = 1'b1; stb.byteSel = BSEL_DATA;
        if (mstDone) begin
          stb.clrPrevRead = 1'b1;
          stb.setErr = mstNack;
          nextState = S_RESP;
        end
      end
      S_RSLA: begin
        cmdValid = 1'b1; cmdStart = 1'b1; stb.byteSel = BSEL_SLA_R;
        if (mstDone) begin
          if (mstNack) begin
            stb.captureFail = 1'b1; nextState = S_EVAL;
          end else nextState = S_RBYTE;
        end
      end
      S_RBYTE: begin
        cmdValid = 1'b1; cmdRead = 1'b1; cmdStop = 1'b1;
        if (mstDone) begin
          stb.captureOk = 1'b1; nextState = S_EVAL;
        end
      end
      S_EVAL: begin
        stb.setPrevRead = 1'b1; stb.incAttempt = 1'b1;
        if (sts.retryOk) nextState = S_BEGIN;
        else begin
          stb.setErr = sts.lastFail && !sts.isAccess;
          nextState = (sts.op == OP_POLL) ? S_CHECK : S_RESP;
        end
      end
      S_CHECK: begin
        if (sts.matchOk) nextState = S_RESP;
        else begin
          stb.loadStep = 1'b1; stb.clrAttempt = 1'b1; nextState = S_STEP;
        end
      end
      S_STEP: if (sts.timerZero) begin
        stb.addElapsed = 1'b1; nextState = S_BEGIN;
      end
      S_RESP: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);

endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq
  import i2c_reg_seq_pkg::*;
#(
  parameter int         CLK_FREQ_HZ = 50_000_000,
  parameter logic [6:0] SLAVE_ADDR  = 7'h20,
  parameter int         GUARD_US    = 250,
  parameter int         STEP_US     = 30,
  parameter int         RETRIES     = 3,
  parameter logic [7:0] FIFO_REG    = 8'h05,
  parameter logic [7:0] ACCESS_REG  = 8'h00,
  parameter int         TMO_W       = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [7:0]       reqReg,
  input  logic [7:0]       reqData,
  input  logic [7:0]       reqSetMask,
  input  logic [7:0]       reqClrMask,
  input  logic [TMO_W-1:0] reqTimeoutUs,
  output logic             rspValid,
  output logic [7:0]       rspData,
  output logic             rspErr,
  output logic             rspTimeout,
  output logic             cmdValid,
  output logic             cmdStart,
  output logic             cmdStop,
  output logic             cmdRead,
  output logic [7:0]       cmdByte,
  input  logic             mstDone,
  input  logic             mstNack,
  input  logic [7:0]       mstRdByte
);

  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int GUARD_CYC  = GUARD_US * CYC_PER_US;
  localparam int STEP_CYC   = STEP_US * CYC_PER_US;

  seqStrobe_t stb;
  seqStatus_t sts;

  i2c_reg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .sts(sts), .stb(stb),
    .cmdValid(cmdValid), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdRead(cmdRead), .mstDone(mstDone), .mstNack(mstNack)
  );

  i2c_reg_seq_dp #(
    .SLAVE_ADDR(SLAVE_ADDR), .GUARD_CYC(GUARD_CYC), .STEP_CYC(STEP_CYC),
    .STEP_US(STEP_US), .RETRIES(RETRIES), .FIFO_REG(FIFO_REG),
    .ACCESS_REG(ACCESS_REG), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .reqOp(reqOp), .reqReg(reqReg), .reqData(reqData),
    .reqSetMask(reqSetMask), .reqClrMask(reqClrMask),
    .reqTimeoutUs(reqTimeoutUs), .mstRdByte(mstRdByte),
    .rspData(rspData), .rspErr(rspErr), .rspTimeout(rspTimeout),
    .cmdByte(cmdByte)
  );

endmodule

// File: rtl/i2c_reg_seq_chk.sv
module i2c_reg_seq_chk #(
  parameter int         GUARD_CYC  = 12500,
  parameter logic [6:0] SLAVE_ADDR = 7'h20
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       rspValid,
  input logic       cmdValid,
  input logic       cmdStart,
  input logic       cmdRead,
  input logic [7:0] cmdByte,
  input logic       mstDone
);

  logic [31:0] sinceRd;
  logic        rdPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRd <= '0;
      rdPending <= 1'b0;
    end else if (cmdValid && cmdRead && mstDone) begin
      sinceRd <= '0;
      rdPending <= 1'b1;
    end else begin
      if (sinceRd != 32'hFFFF_FFFF) sinceRd <= sinceRd + 1'b1;
      if (cmdValid && cmdStart && !cmdByte[0] && mstDone) rdPending <= 1'b0;
    end
  end

  // R3: write-led transaction after a read waits out the guard
  p_guard_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdStart && !cmdByte[0] && rdPending |-> sinceRd >= 32'(GUARD_CYC));

  // R1: every START carries the slave address
  p_sla_on_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdStart |-> cmdByte[7:1] == SLAVE_ADDR);

  // R2: read byte never opens a transaction
  p_read_no_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdRead |-> !cmdStart);

  // R2: a command is held unchanged until the master completes it
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !mstDone |=> cmdValid && $stable(cmdByte) && $stable(cmdStart) && $stable(cmdRead));

  // R10: response is a single-cycle pulse
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10: idle block drives no bus command
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid && !rspValid);

endmodule

bind i2c_reg_seq i2c_reg_seq_chk #(
  .GUARD_CYC(GUARD_CYC), .SLAVE_ADDR(SLAVE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .cmdValid(cmdValid), .cmdStart(cmdStart), .cmdRead(cmdRead),
  .cmdByte(cmdByte), .mstDone(mstDone)
);

// File: tb/tb_i2c_reg_seq.sv
module tb_i2c_reg_seq;

  localparam int CLK_HZ    = 2_000_000;
  localparam int GUARD_US  = 250;
  localparam int STEP_US   = 30;
  localparam int GUARD_CYC = GUARD_US * (CLK_HZ / 1_000_000);
  localparam int TMO_W     = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [7:0] reqReg = 8'd0, reqData = 8'd0, reqSetMask = 8'd0, reqClrMask = 8'd0;
  logic [TMO_W-1:0] reqTimeoutUs = '0;
  logic rspValid, rspErr, rspTimeout;
  logic [7:0] rspData;
  logic cmdValid, cmdStart, cmdStop, cmdRead;
  logic [7:0] cmdByte;
  logic mstDone = 1'b0, mstNack = 1'b0;
  logic [7:0] mstRdByte = 8'd0;

  always #10 clk = ~clk;

  i2c_reg_seq #(.CLK_FREQ_HZ(CLK_HZ), .GUARD_US(GUARD_US), .STEP_US(STEP_US),
                .TMO_W(TMO_W)) dut (.*);

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave and byte-level master model
  logic [7:0] regs [8];
  int ffLeft [8];
  bit nackSla = 0, nackData = 0;
  bit busOpen = 0, prevRdBench = 0;
  int ptr = 0, byteIdx = 0, lastRdCyc = 0, lastEndCyc = 0, lastWrGap = 0;
  int nReads = 0, nStarts = 0;

  initial begin
    for (int i = 0; i < 8; i++) begin regs[i] = 8'h00; ffLeft[i] = 0; end
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        int seen;
        bit nk;
        seen = cyc;
        nk = 0;
        @(negedge clk);
        if (cmdStart) begin
          chk(!busOpen, "R2 no repeated START", busOpen, 0);
          busOpen = 1; byteIdx = 0; nStarts++;
          chk(cmdByte[7:1] == 7'h20, "R1 slave address", cmdByte[7:1], 32);
          nk = nackSla;
          if (!cmdByte[0]) begin
            lastWrGap = seen - lastEndCyc;
            if (prevRdBench)
              chk(seen - lastRdCyc >= GUARD_CYC, "R3 guard after read", seen - lastRdCyc, GUARD_CYC);
            prevRdBench = 0;
          end
        end else if (cmdRead) begin
          nReads++;
          if (ffLeft[ptr] > 0) begin ffLeft[ptr]--; mstRdByte = 8'hFF; end
          else mstRdByte = regs[ptr];
          prevRdBench = 1; lastRdCyc = cyc + 1;
        end else begin
          if (byteIdx == 0) ptr = int'(cmdByte[2:0]);
          else if (nackData) nk = 1;
          else regs[ptr] = cmdByte;
          byteIdx++;
        end
        mstNack = nk; mstDone = 1'b1;
        if (cmdStop || nk) begin busOpen = 0; lastEndCyc = cyc; end
        @(negedge clk);
        mstDone = 1'b0; mstNack = 1'b0;
      end
    end
  end

  logic [7:0] rD;
  bit rE, rT;

  task automatic doReq(input int op, input int rg, input int d, input int sm,
                       input int cm, input int tmo);
    nReads = 0; nStarts = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqReg = 8'(rg); reqData = 8'(d);
    reqSetMask = 8'(sm); reqClrMask = 8'(cm); reqTimeoutUs = TMO_W'(tmo);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    rD = rspData; rE = rspErr; rT = rspTimeout;
    @(negedge clk);
    chk(!rspValid, "R10 single pulse", rspValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !cmdValid && !rspValid, "R11 reset state", {reqReady, cmdValid, rspValid}, 4);

    // R1/R2 sweep over all registers
    for (int r = 0; r < 8; r++) begin
      int d;
      d = (r * 37 + 11) & 255;
      doReq(1, r, d, 0, 0, 0);
      chk(regs[r] == 8'(d) && !rE, "R1 write lands", regs[r], d);
      doReq(0, r, 0, 0, 0, 0);
      chk(rD == 8'(d) && nReads == 1 && nStarts == 2, "R2 read value", rD, d);
    end
    chk(!reqReady || !cmdValid, "R10 idle quiet", cmdValid, 0);

    // R3 write after write: no guard
    doReq(1, 1, 8'h10, 0, 0, 0);
    doReq(1, 1, 8'h20, 0, 0, 0);
    chk(lastWrGap < GUARD_CYC / 10, "R3 no guard write-write", lastWrGap, 0);

    // R4 retry then good value
    regs[2] = 8'h33; ffLeft[2] = 2;
    doReq(0, 2, 0, 0, 0, 0);
    chk(rD == 8'h33 && nReads == 3, "R4 retry to value", rD, 8'h33);
    ffLeft[2] = 5;
    doReq(0, 2, 0, 0, 0, 0);
    chk(rD == 8'hFF && nReads == 3 && !rE, "R4 retries exhausted", nReads, 3);
    ffLeft[2] = 0;

    // R5 FIFO no retry
    regs[5] = 8'h44; ffLeft[5] = 1;
    doReq(0, 5, 0, 0, 0, 0);
    chk(rD == 8'hFF && nReads == 1, "R5 fifo single attempt", nReads, 1);
    ffLeft[5] = 0;

    // R6 failed reads
    nackSla = 1;
    doReq(0, 2, 0, 0, 0, 0);
    chk(rD == 8'hFF && rE && nStarts == 3, "R6 fail sets err", {rE, nStarts}, 32'h13);
    doReq(0, 0, 0, 0, 0, 0);
    chk(rD == 8'hFF && !rE && nStarts == 3, "R6 access fail silent", rE, 0);
    // R7 write NACK on slave address
    regs[4] = 8'h66;
    doReq(1, 4, 8'h77, 0, 0, 0);
    chk(rE && regs[4] == 8'h66, "R7 write nack address", regs[4], 8'h66);
    nackSla = 0;
    nackData = 1;
    doReq(1, 4, 8'h77, 0, 0, 0);
    chk(rE && regs[4] == 8'h66, "R7 write nack data", regs[4], 8'h66);
    nackData = 0;

    // R8 poll match
    regs[6] = 8'h81;
    doReq(2, 6, 0, 8'h80, 8'h08, 60);
    chk(rD == 8'h81 && !rT && nReads == 1, "R8 poll match", rD, 8'h81);
    regs[6] = 8'h89;
    doReq(2, 6, 0, 8'h80, 8'h08, 60);
    chk(rT && nReads == 2, "R8 clear mask blocks", nReads, 2);
    // retry vs match collision
    regs[6] = 8'h81; ffLeft[6] = 1;
    doReq(2, 6, 0, 8'h80, 8'h00, 60);
    chk(rD == 8'h81 && !rT && nReads == 2, "R4 retry before poll match", rD, 8'h81);

    // R9 timeout sweep
    regs[6] = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int t, exp;
      case (i)
        0: t = 0;   1: t = 1;   2: t = 30;  3: t = 31;
        4: t = 60;  5: t = 61;  6: t = 90;  default: t = 119;
      endcase
      exp = (t + STEP_US - 1) / STEP_US;
      doReq(2, 6, 0, 8'h01, 8'h00, t);
      chk(rT && nReads == exp, "R9 poll read count", nReads, exp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule